// File: doc/BRIEF.md
# Serial Flash Write-Protect Controller

This block is the command front end of a serial NOR flash, cut down to the part that decides whether a write may happen. It watches an SPI mode-0 bus (chip select, serial clock, serial data in), oversampled by the system clock. It also watches an active-low write-protect pin. It keeps the status byte that carries the protection settings. It decodes write enable, read status, write status, page program, sector erase and bulk erase. For every program or erase request that meets the entry conditions, it emits a one-cycle grant or deny pulse, together with the target address and the kind of operation.

A downstream array controller acts on a grant; a deny means that the request fell inside the protected region. No array and no real program timing are modelled here. After an accepted status write, program or erase, a down-counter of `BUSY_CYCLES` system clocks keeps the busy flag set in place of that timing.

All bus inputs are assumed to be synchronous to `clk` already. A command is evaluated in the clock cycle in which chip select is seen to rise. The serial output goes out together with an enable, so that a pad cell can form the high-impedance state.

Top module: `flash_wp_ctrl`

## Requirements
- R1: After reset the status byte reads 0x00, `misoEn` is 0, and no grant or deny pulse appears.
- R2: Opcode 0x06 with exactly 8 bits sets the write-enable flag (status bit 1). A read then returns 0x02.
- R3: Opcode 0x05 holds `misoEn` low during the opcode bits. From the first serial-clock fall after the 8th rise, it shifts out the status byte MSB first, one bit per fall, and repeats the byte for as long as chip select stays low. `misoEn` is 0 while chip select is high.
- R4: Opcode 0x01 with exactly 16 bits and the write-enable flag set loads status bit 7 (write-disable) and bits 4:2 (protect code) from the data byte. Bits 6:5 read as 0. The busy flag (bit 0) is then 1 for `BUSY_CYCLES` clocks, and when it drops the write-enable flag drops with it.
- R5: When status bit 7 is 1 and `wpN` is low, a status write is refused. Bits 7 and 4:2 keep their values and the write-enable flag is cleared. With `wpN` high, the write is accepted.
- R6: Page program (0x02: opcode, 24-bit address, one or more whole data bytes) and sector erase (0xD8: opcode plus 24-bit address) use sector = address bits 23:18. The target is protected for protect code 7. For protect codes 1 to 6, it is protected when sector >= 64 - 2^(code-1); code 0 protects nothing. A protected target gives `denyValid` and clears the write-enable flag. Any other target gives `grantValid` and starts busy. The address is reported on `opAddr`, and `opKind` is 0 for program and 1 for sector erase.
- R7: Bulk erase (0xC7, 8 bits) gives `grantValid` with `opKind` = 2 only when the protect code is 000. Otherwise it gives `denyValid` and clears the write-enable flag.
- R8: A status write, program or erase sent while the write-enable flag is 0 has no effect: no pulse, no status change.
- R9: A command whose bit count differs from its required length is ignored.
- R10: While the busy flag is 1, every command except read status is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock, mode 0 |
| mosi | input | 1 | Serial data in, MSB first |
| wpN | input | 1 | Active-low write-protect pin |
| miso | output | 1 | Serial data out |
| misoEn | output | 1 | Output enable for `miso`; 0 means high impedance |
| grantValid | output | 1 | One-cycle pulse: program or erase allowed |
| denyValid | output | 1 | One-cycle pulse: program or erase refused by protection |
| opAddr | output | ADDR_W | Target address of the pulse (0 for bulk erase) |
| opKind | output | 2 | 0 program, 1 sector erase, 2 bulk erase |

## Verification
A wrong protect code or a wrong write-disable bit would not stay hidden. It shows up on the very next program or erase as a grant that should have been a deny, or the reverse, on the cycle after chip select rises. It also appears in the next status read, so the bench sweeps every protect code across all 64 sectors and compares each pulse with the threshold computed in the bench. A stuck busy or write-enable flag turns up on the next status read or as a missing pulse. The bench therefore reads status back after each refused, ignored or accepted command.

// File: rtl/wp_pkg.sv
package wp_pkg;

  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_PROG = 8'h02;
  localparam logic [7:0] OP_SECT = 8'hD8;
  localparam logic [7:0] OP_BULK = 8'hC7;

  typedef enum logic [1:0] {
    KIND_PROG = 2'd0,
    KIND_SECT = 2'd1,
    KIND_BULK = 2'd2
  } opKind_t;

  // control -> datapath strobes
  typedef struct packed {
    logic setWel;
    logic clrWel;
    logic writeStatus;
    logic startBusy;
  } strobe_t;

endpackage

// File: rtl/wp_datapath.sv
module wp_datapath
  import wp_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int CNT_W       = 12,
  parameter int BUSY_CYCLES = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic              mosi,
  input  strobe_t           stb,
  output logic              csRise,
  output logic [CNT_W-1:0]  bitCnt,
  output logic [7:0]        opReg,
  output logic [ADDR_W-1:0] addrReg,
  output logic [7:0]        status,
  output logic              miso,
  output logic              misoEn
);

  localparam int BUSY_W = $clog2(BUSY_CYCLES + 1);
  localparam int SHIFT_W = (ADDR_W + 8 > 16) ? ADDR_W + 8 : 16;

  logic sclkQ, csQ;
  logic sclkRise, sclkFall;
  logic [SHIFT_W-1:0] shiftReg;
  logic [7:0] dataReg;
  logic [2:0] outIdx;
  logic srwd, wel, wip;
  logic [2:0] bp;
  logic [BUSY_W-1:0] busyCnt;
  logic busyDone;

  assign sclkRise = sclk & ~sclkQ;
  assign sclkFall = ~sclk & sclkQ;
  assign csRise   = csN & ~csQ;
  assign status   = {srwd, 2'b00, bp, wel, wip};
  assign busyDone = wip && (busyCnt == BUSY_W'(1));

  // serial front end
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkQ    <= 1'b0;
      csQ      <= 1'b1;
      shiftReg <= '0;
      bitCnt   <= '0;
      opReg    <= '0;
      dataReg  <= '0;
      addrReg  <= '0;
      outIdx   <= '0;
      miso     <= 1'b0;
      misoEn   <= 1'b0;
    end else begin
      sclkQ <= sclk;
      csQ   <= csN;
      if (csN) begin
        bitCnt <= '0;
        outIdx <= '0;
        misoEn <= 1'b0;
        opReg  <= '0;
      end else begin
        if (sclkRise) begin
          shiftReg <= {shiftReg[SHIFT_W-2:0], mosi};
          if (bitCnt != '1) bitCnt <= bitCnt + CNT_W'(1);
          if (bitCnt == CNT_W'(7))  opReg   <= {shiftReg[6:0], mosi};
          if (bitCnt == CNT_W'(15)) dataReg <= {shiftReg[6:0], mosi};
          if (bitCnt == CNT_W'(ADDR_W + 7)) addrReg <= {shiftReg[ADDR_W-2:0], mosi};
        end
        if (sclkFall && bitCnt >= CNT_W'(8) && opReg == OP_RDSR) begin
          miso   <= status[3'd7 - outIdx];
          outIdx <= outIdx + 3'd1;
          misoEn <= 1'b1;
        end
      end
    end
  end

  // status register and busy countdown
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srwd    <= 1'b0;
      bp      <= '0;
      wel     <= 1'b0;
      wip     <= 1'b0;
      busyCnt <= '0;
    end else begin
      if (stb.writeStatus) begin
        srwd <= dataReg[7];
        bp   <= dataReg[4:2];
      end
      if (stb.setWel)                 wel <= 1'b1;
      else if (stb.clrWel || busyDone) wel <= 1'b0;
      if (stb.startBusy) begin
        wip     <= 1'b1;
        busyCnt <= BUSY_W'(BUSY_CYCLES);
      end else if (wip) begin
        busyCnt <= busyCnt - BUSY_W'(1);
        if (busyDone) wip <= 1'b0;
      end
    end
  end

  // R10
  no_start_while_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.startBusy |-> !wip);
  // R4
  wel_drops_with_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wip) |-> !wel);
  // R3
  hiz_when_deselected_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csN && $past(csN)) |-> !misoEn);

endmodule

// File: rtl/wp_control.sv
module wp_control
  import wp_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int SECTOR_W = 6,
  parameter int CNT_W    = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csRise,
  input  logic [CNT_W-1:0]  bitCnt,
  input  logic [7:0]        opReg,
  input  logic [ADDR_W-1:0] addrReg,
  input  logic [7:0]        status,
  input  logic              wpN,
  output strobe_t           stb,
  output logic              grantValid,
  output logic              denyValid,
  output logic [ADDR_W-1:0] opAddr,
  output logic [1:0]        opKind
);

  localparam int NUM_SECT = 1 << SECTOR_W;
  localparam int ADDR_LEN = 8 + ADDR_W;

  logic wip, wel, srwd, hwProt, inProt, lenProg;
  logic [2:0] bp;
  logic [SECTOR_W-1:0] sector;
  logic [SECTOR_W:0] protCount;
  logic grantD, denyD;
  opKind_t kindD;
  logic [ADDR_W-1:0] addrD;

  assign wip    = status[0];
  assign wel    = status[1];
  assign bp     = status[4:2];
  assign srwd   = status[7];
  assign hwProt = srwd & ~wpN;
  assign sector = addrReg[ADDR_W-1 -: SECTOR_W];

  always_comb begin
    if (bp == 3'd7)      protCount = (SECTOR_W+1)'(NUM_SECT);
    else if (bp == 3'd0) protCount = '0;
    else                 protCount = (SECTOR_W+1)'(1) << (bp - 3'd1);
  end
  assign inProt  = ({1'b0, sector} >= ((SECTOR_W+1)'(NUM_SECT) - protCount)) && (bp != 3'd0);
  assign lenProg = (bitCnt >= CNT_W'(ADDR_LEN + 8)) && (bitCnt[2:0] == 3'd0);

  always_comb begin
    stb    = '0;
    grantD = 1'b0;
    denyD  = 1'b0;
    kindD  = KIND_PROG;
    addrD  = addrReg;
    if (csRise && !wip) begin
      unique case (opReg)
        OP_WREN: if (bitCnt == CNT_W'(8)) stb.setWel = 1'b1;
        OP_WRSR: if (bitCnt == CNT_W'(16) && wel) begin
          if (hwProt) stb.clrWel = 1'b1;
          else begin
            stb.writeStatus = 1'b1;
            stb.startBusy   = 1'b1;
          end
        end
        OP_PROG, OP_SECT: begin
          kindD = (opReg == OP_PROG) ? KIND_PROG : KIND_SECT;
          if (wel && ((opReg == OP_PROG) ? lenProg : (bitCnt == CNT_W'(ADDR_LEN)))) begin
            if (inProt) begin
              denyD      = 1'b1;
              stb.clrWel = 1'b1;
            end else begin
              grantD        = 1'b1;
              stb.startBusy = 1'b1;
            end
          end
        end
        OP_BULK: begin
          kindD = KIND_BULK;
          addrD = '0;
          if (wel && bitCnt == CNT_W'(8)) begin
            if (bp != 3'd0) begin
              denyD      = 1'b1;
              stb.clrWel = 1'b1;
            end else begin
              grantD        = 1'b1;
              stb.startBusy = 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      grantValid <= 1'b0;
      denyValid  <= 1'b0;
      opAddr     <= '0;
      opKind     <= '0;
    end else begin
      grantValid <= grantD;
      denyValid  <= denyD;
      if (grantD || denyD) begin
        opAddr <= addrD;
        opKind <= kindD;
      end
    end
  end

  // R6
  one_verdict_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({grantValid, denyValid}));
  // R7
  bulk_needs_clear_bp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid && opKind == 2'd2) |-> (status[4:2] == 3'd0));
  // R6
  deny_clears_wel_chk: assert property (@(posedge clk) disable iff (!rstN)
    denyValid |-> !status[1]);

endmodule

// File: rtl/flash_wp_ctrl.sv
module flash_wp_ctrl
  import wp_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int SECTOR_W    = 6,
  parameter int CNT_W       = 12,
  parameter int BUSY_CYCLES = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic              mosi,
  input  logic              wpN,
  output logic              miso,
  output logic              misoEn,
  output logic              grantValid,
  output logic              denyValid,
  output logic [ADDR_W-1:0] opAddr,
  output logic [1:0]        opKind
);

  strobe_t stb;
  logic csRise;
  logic [CNT_W-1:0] bitCnt;
  logic [7:0] opReg, status;
  logic [ADDR_W-1:0] addrReg;

  wp_datapath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .BUSY_CYCLES(BUSY_CYCLES)) u_dp (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .mosi(mosi), .stb(stb),
    .csRise(csRise), .bitCnt(bitCnt), .opReg(opReg), .addrReg(addrReg),
    .status(status), .miso(miso), .misoEn(misoEn)
  );

  wp_control #(.ADDR_W(ADDR_W), .SECTOR_W(SECTOR_W), .CNT_W(CNT_W)) u_ctl (
    .clk(clk), .rstN(rstN), .csRise(csRise), .bitCnt(bitCnt), .opReg(opReg),
    .addrReg(addrReg), .status(status), .wpN(wpN), .stb(stb),
    .grantValid(grantValid), .denyValid(denyValid), .opAddr(opAddr), .opKind(opKind)
  );

  // R5
  hw_protect_blocks_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.writeStatus && !wpN) |-> !status[7]);

endmodule

// File: tb/flash_wp_ctrl_tb.sv
module flash_wp_ctrl_tb;

  localparam int BUSY = 100;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, sclk = 1'b0, mosi = 1'b0, wpN = 1'b1;
  logic miso, misoEn, grantValid, denyValid;
  logic [23:0] opAddr;
  logic [1:0] opKind;

  int errors = 0, checks = 0;
  int gCnt = 0, dCnt = 0;
  logic [23:0] lastAddr = '0;
  logic [1:0] lastKind = '0;
  int cyc = 0;

  always #5 clk = ~clk;

  flash_wp_ctrl #(.BUSY_CYCLES(BUSY)) u_dut (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .mosi(mosi), .wpN(wpN),
    .miso(miso), .misoEn(misoEn), .grantValid(grantValid), .denyValid(denyValid),
    .opAddr(opAddr), .opKind(opKind)
  );

  always @(negedge clk) begin
    cyc++;
    if (rstN && (grantValid || denyValid)) begin
      if (grantValid) gCnt++;
      if (denyValid) dCnt++;
      lastAddr = opAddr;
      lastKind = opKind;
    end
    if (cyc > 190000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: act=%0d exp<190000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic bitX(input logic d, output logic q, output logic e);
    mosi = d;
    sclk = 1'b1;
    q = miso;
    e = misoEn;
    @(negedge clk);
    sclk = 1'b0;
    @(negedge clk);
  endtask

  task automatic sendCmd(input logic [63:0] v, input int n);
    logic q, e;
    csN = 1'b0;
    @(negedge clk);
    for (int i = n - 1; i >= 0; i--) bitX(v[i], q, e);
    csN = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic rdsr(input int nBytes, output logic [23:0] data,
                      output logic earlyEn, output logic lateEn);
    logic q, e;
    data = '0;
    earlyEn = 1'b0;
    lateEn = 1'b1;
    csN = 1'b0;
    @(negedge clk);
    for (int i = 7; i >= 0; i--) begin
      bitX(8'h05 >> i, q, e);
      earlyEn |= e;
    end
    for (int i = 0; i < 8 * nBytes; i++) begin
      bitX(1'b0, q, e);
      data = {data[22:0], q};
      lateEn &= e;
    end
    csN = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [7:0] st();
    return 8'h00;
  endfunction

  task automatic expStatus(input string req, input logic [7:0] exp);
    logic [23:0] d;
    logic ee, le;
    rdsr(1, d, ee, le);
    chk(req, {24'h0, d[7:0]}, {24'h0, exp});
  endtask

  task automatic setBp(input logic [2:0] b);
    sendCmd(64'h06, 8);
    sendCmd({48'h0, 8'h01, 3'b000, b, 2'b00}, 16);
    repeat (BUSY + 4) @(negedge clk);
  endtask

  initial begin
    logic [23:0] d;
    logic ee, le;
    int g0, d0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    chk("R1 misoEn", misoEn, 0);
    chk("R1 pulses", grantValid | denyValid, 0);
    expStatus("R1 status", 8'h00);

    // R2 write enable
    sendCmd(64'h06, 8);
    expStatus("R2 wel set", 8'h02);

    // R4 status write, busy then cleared
    sendCmd({48'h0, 16'h019C}, 16);
    expStatus("R4 busy during write", 8'h9F);
    repeat (BUSY) @(negedge clk);
    expStatus("R4 after busy", 8'h9C);

    // R3 streaming repeats, hi-z during opcode and after
    rdsr(3, d, ee, le);
    chk("R3 three repeats", d, 24'h9C9C9C);
    chk("R3 no drive during opcode", ee, 0);
    chk("R3 driven in data phase", le, 1);
    chk("R3 hi-z after deselect", misoEn, 0);

    // R5 hardware protection refuses status write
    wpN = 1'b0;
    sendCmd(64'h06, 8);
    expStatus("R5 wel before refused write", 8'h9E);
    sendCmd({48'h0, 16'h0100}, 16);
    expStatus("R5 refused write keeps bits, clears wel", 8'h9C);
    wpN = 1'b1;
    sendCmd(64'h06, 8);
    sendCmd({48'h0, 16'h0100}, 16);
    repeat (BUSY + 4) @(negedge clk);
    expStatus("R5 pin high allows write", 8'h00);

    // R8 no write enable: nothing happens
    g0 = gCnt; d0 = dCnt;
    sendCmd({32'h0, 8'hD8, 24'h123456}, 32);
    sendCmd({48'h0, 16'h011C}, 16);
    sendCmd(64'hC7, 8);
    chk("R8 no pulses without wel", gCnt + dCnt, g0 + d0);
    expStatus("R8 status untouched", 8'h00);

    // R9 wrong lengths
    sendCmd(64'h06, 8);
    sendCmd({33'h0, 8'hD8, 23'h12345}, 31);
    sendCmd({32'h0, 8'h02, 24'h000100}, 32);
    sendCmd({48'h0, 16'h011C}, 15);
    sendCmd({55'h0, 9'h18E}, 9);
    chk("R9 no pulses for bad lengths", gCnt + dCnt, g0 + d0);
    expStatus("R9 status and wel kept", 8'h02);
    sendCmd({24'h0, 8'h02, 24'h000100, 8'hA5}, 40);
    chk("R6 program grant count", gCnt, g0 + 1);
    chk("R6 program kind", lastKind, 0);
    chk("R6 program addr", lastAddr, 24'h000100);
    repeat (BUSY + 4) @(negedge clk);

    // R10 busy ignores commands
    sendCmd(64'h06, 8);
    g0 = gCnt;
    sendCmd(64'hC7, 8);
    chk("R7 bulk grant with bp 0", gCnt, g0 + 1);
    chk("R7 bulk kind", lastKind, 2);
    sendCmd(64'hC7, 8);
    sendCmd({48'h0, 16'h011C}, 16);
    chk("R10 no second grant while busy", gCnt, g0 + 1);
    repeat (BUSY + 4) @(negedge clk);
    expStatus("R10 status write ignored while busy", 8'h00);

    // R6/R7 sweep: every protect code over every sector
    for (int b = 0; b < 8; b++) begin
      setBp(3'(b));
      expStatus("R4 protect code loaded", 8'(b << 2));
      for (int s = 0; s < 64; s++) begin
        logic [23:0] a;
        logic prot;
        a = {6'(s), 18'(s * 4099 + 7)};
        if (b == 0) prot = 1'b0;
        else if (b == 7) prot = 1'b1;
        else prot = (s >= 64 - (1 << (b - 1)));
        g0 = gCnt; d0 = dCnt;
        sendCmd(64'h06, 8);
        sendCmd({32'h0, 8'hD8, a}, 32);
        chk("R6 sector verdict grant", gCnt - g0, prot ? 0 : 1);
        chk("R6 sector verdict deny", dCnt - d0, prot ? 1 : 0);
        chk("R6 sector addr", lastAddr, a);
        chk("R6 sector kind", lastKind, 1);
        if (!prot) repeat (BUSY + 2) @(negedge clk);
      end
      if (b != 0) begin
        d0 = dCnt;
        sendCmd(64'h06, 8);
        sendCmd(64'hC7, 8);
        chk("R7 bulk denied with bp set", dCnt - d0, 1);
        expStatus("R7 deny clears wel", 8'(b << 2));
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule